// File: doc/BRIEF.md
# Secure-Boot Selector Validator

This block takes the four bytes of a fuse security section, presented together with a one-cycle valid strobe. It checks the 16-bit crypto-select field held in the upper two bytes. A correctly formed field yields a secure-boot enable and one of a small set of 32-bit selection constants. A field that is still blank (all ones) leaves secure boot off and raises no error. Any other malformed field raises an invalid flag.

The field protects itself with redundancy. In the low byte each bit must match its bit-mirror partner, and at most one mirrored pair may be cleared; the position of that pair sets a base of 0, 16, 32 or 48. In the high byte the two nibbles must be bitwise complements. The low nibble of the high byte is added to the base to form an index into the constant table. The two identity bytes at the bottom of the section are passed through unchanged. Every result is registered one cycle after the strobe, and a one-cycle done pulse marks it.

Top module: `sbsel_validator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero.
- R2: A strobe on `in_valid` makes `done` high in the next cycle only. Without a strobe `done` is low and all other outputs keep their values.
- R3: On a strobe, `ext_id` takes `in_bytes[7:0]` and `serial_id` takes `in_bytes[15:8]`, whatever the select field holds.
- R4: The select field is `in_bytes[31:16]` (low byte `[23:16]`, high byte `[31:24]`). A value of 0xFFFF gives `boot_en`=0, `bad_sel`=0 and `sel_const`=0.
- R5: If any bit k (k=0..3) of the low byte differs from bit 7-k, the field is invalid (`bad_sel`=1).
- R6: If two or more mirrored pairs of the low byte are both zero, the field is invalid.
- R7: If the high byte's low nibble XOR its high nibble is not 0xF, the field is invalid.
- R8: The index is 16 times the position of the single zero pair (0 when no pair is zero), plus the high byte's low nibble. An index of 2 or more is invalid.
- R9: A valid field sets `boot_en`=1 and `bad_sel`=0. Index 0 gives `sel_const`=0x08000100 and index 1 gives 0x0C000180.
- R10: Whenever `boot_en` is 0, `sel_const` is 0. An invalid field never sets `boot_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Section bytes are present this cycle |
| in_bytes | input | 32 | Section bytes, byte 0 in bits [7:0] |
| boot_en | output | 1 | Secure boot enabled by a valid field |
| sel_const | output | 32 | Selected constant, zero unless enabled |
| ext_id | output | 8 | External identity byte |
| serial_id | output | 8 | Serial identity byte |
| bad_sel | output | 1 | Select field malformed |
| done | output | 1 | One-cycle result strobe |

## Verification
Directed fields hit each verdict in turn. The blank field tells "not programmed" apart from "invalid". The 0xFF and 0x7E low bytes paired with the 0xF0 and 0xE1 high bytes reach both legal indices. A cleared pair at position one reaches index 16, which the range rule must reject even though every redundancy check passes. Single-sided mirror breaks, double zero pairs and broken nibble complements exercise each rejection on its own. Idle gaps between strobes show that results hold, and a long pseudo-random sweep, compared every clock against a behavioural model, covers mixed failures whose priority would not matter if each rule were wired correctly.

// File: rtl/sbsel_pkg.sv
package sbsel_pkg;

    localparam int SB_BYTE_W  = 8;
    localparam int SB_CONST_W = 32;
    localparam int SB_IDX_W   = 8;

    typedef enum logic [2:0] {
        VERD_BLANK  = 3'd0,
        VERD_GOOD   = 3'd1,
        VERD_ASYM   = 3'd2,
        VERD_MULTI  = 3'd3,
        VERD_NIBBLE = 3'd4,
        VERD_RANGE  = 3'd5
    } verdict_e;

endpackage

// File: rtl/sbsel_mirror_chk.sv
module sbsel_mirror_chk #(
    parameter int BYTE_W = 8,
    parameter int STEP   = 16,
    parameter int IDX_W  = 8
) (
    input  logic [BYTE_W-1:0] lo_byte,
    output logic              sym_ok,
    output logic              multi_zero,
    output logic [IDX_W-1:0]  base
);
    localparam int PAIRS = BYTE_W / 2;

    logic [PAIRS-1:0] mism;
    logic [PAIRS-1:0] pair_zero;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign mism[k]      = lo_byte[k] ^ lo_byte[BYTE_W-1-k];
        assign pair_zero[k] = ~lo_byte[k] & ~lo_byte[BYTE_W-1-k];
    end

    always_comb begin
        int zcnt;
        logic found;
        zcnt  = 0;
        found = 1'b0;
        base  = '0;
        for (int k = 0; k < PAIRS; k++) begin
            if (pair_zero[k]) begin
                zcnt = zcnt + 1;
                if (!found) begin
                    base  = IDX_W'(k * STEP);
                    found = 1'b1;
                end
            end
        end
        sym_ok     = ~|mism;
        multi_zero = (zcnt > 1);
    end

endmodule

// File: rtl/sbsel_comp_chk.sv
module sbsel_comp_chk #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]   hi_byte,
    output logic                comp_ok,
    output logic [BYTE_W/2-1:0] low_nib
);
    localparam int HALF = BYTE_W / 2;

    logic [HALF-1:0] upper_nib;

    assign low_nib   = hi_byte[HALF-1:0];
    assign upper_nib = hi_byte[BYTE_W-1:HALF];
    assign comp_ok   = &(low_nib ^ upper_nib);

endmodule

// File: rtl/sbsel_const_sel.sv
module sbsel_const_sel #(
    parameter int                           CONST_W   = 32,
    parameter int                           NUM_CONST = 2,
    parameter int                           IDX_W     = 8,
    parameter logic [NUM_CONST*CONST_W-1:0] TABLE     = '0
) (
    input  logic [IDX_W-1:0]   idx,
    output logic               in_range,
    output logic [CONST_W-1:0] value
);
    logic [NUM_CONST-1:0]  hit;
    logic [CONST_W-1:0]    term [NUM_CONST];

    for (genvar e = 0; e < NUM_CONST; e++) begin : g_entry
        assign hit[e]  = (idx == IDX_W'(e));
        assign term[e] = hit[e] ? TABLE[e*CONST_W +: CONST_W] : '0;
    end

    always_comb begin
        value = '0;
        for (int e = 0; e < NUM_CONST; e++) begin
            value = value | term[e];
        end
        in_range = |hit;
    end

endmodule

// File: rtl/sbsel_validator.sv
module sbsel_validator
    import sbsel_pkg::*;
#(
    parameter int                           BYTE_W    = SB_BYTE_W,
    parameter int                           CONST_W   = SB_CONST_W,
    parameter int                           IDX_W     = SB_IDX_W,
    parameter int                           NUM_CONST = 2,
    parameter logic [NUM_CONST*CONST_W-1:0] TABLE     = {32'h0C00_0180, 32'h0800_0100}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [4*BYTE_W-1:0] in_bytes,
    output logic                boot_en,
    output logic [CONST_W-1:0]  sel_const,
    output logic [BYTE_W-1:0]   ext_id,
    output logic [BYTE_W-1:0]   serial_id,
    output logic                bad_sel,
    output logic                done
);
    localparam int FIELD_W = 2 * BYTE_W;
    localparam int HALF    = BYTE_W / 2;

    typedef struct packed {
        logic               done;
        logic               boot;
        logic               bad;
        logic [CONST_W-1:0] cnst;
        logic [BYTE_W-1:0]  ext;
        logic [BYTE_W-1:0]  ser;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [FIELD_W-1:0] field;
    logic [BYTE_W-1:0]  lo_b, hi_b;
    logic               sym_ok, multi_zero, comp_ok, in_range;
    logic [IDX_W-1:0]   base, index;
    logic [HALF-1:0]    low_nib;
    logic [CONST_W-1:0] table_val;
    verdict_e           verdict;

    assign lo_b  = in_bytes[2*BYTE_W +: BYTE_W];
    assign hi_b  = in_bytes[3*BYTE_W +: BYTE_W];
    assign field = {hi_b, lo_b};

    sbsel_mirror_chk #(.BYTE_W(BYTE_W), .STEP(16), .IDX_W(IDX_W)) u_mirror (
        .lo_byte    (lo_b),
        .sym_ok     (sym_ok),
        .multi_zero (multi_zero),
        .base       (base)
    );

    sbsel_comp_chk #(.BYTE_W(BYTE_W)) u_comp (
        .hi_byte (hi_b),
        .comp_ok (comp_ok),
        .low_nib (low_nib)
    );

    assign index = base + IDX_W'(low_nib);

    sbsel_const_sel #(
        .CONST_W   (CONST_W),
        .NUM_CONST (NUM_CONST),
        .IDX_W     (IDX_W),
        .TABLE     (TABLE)
    ) u_const (
        .idx      (index),
        .in_range (in_range),
        .value    (table_val)
    );

    always_comb begin
        if (field == '1)        verdict = VERD_BLANK;
        else if (!sym_ok)       verdict = VERD_ASYM;
        else if (multi_zero)    verdict = VERD_MULTI;
        else if (!comp_ok)      verdict = VERD_NIBBLE;
        else if (!in_range)     verdict = VERD_RANGE;
        else                    verdict = VERD_GOOD;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            st_d.done = 1'b1;
            st_d.ext  = in_bytes[0 +: BYTE_W];
            st_d.ser  = in_bytes[BYTE_W +: BYTE_W];
            st_d.boot = (verdict == VERD_GOOD);
            st_d.bad  = (verdict != VERD_GOOD) && (verdict != VERD_BLANK);
            st_d.cnst = (verdict == VERD_GOOD) ? table_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign boot_en   = st_q.boot;
    assign bad_sel   = st_q.bad;
    assign sel_const = st_q.cnst;
    assign ext_id    = st_q.ext;
    assign serial_id = st_q.ser;

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);                                              // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);                                            // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({boot_en, bad_sel, sel_const, ext_id, serial_id})); // R2
    AST_ID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ext_id == $past(in_bytes[BYTE_W-1:0]))
                  && (serial_id == $past(in_bytes[2*BYTE_W-1:BYTE_W])));  // R3
    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bytes[4*BYTE_W-1:2*BYTE_W] == '1) |=> (!boot_en && !bad_sel)); // R4
    AST_NIBBLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bytes[4*BYTE_W-1:2*BYTE_W] != '1
         && ((in_bytes[3*BYTE_W +: HALF] ^ in_bytes[3*BYTE_W+HALF +: HALF]) != '1))
        |=> bad_sel);                                                    // R7
    AST_BOOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        boot_en |-> !bad_sel);                                           // R10
    AST_CONST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_en |-> (sel_const == '0));                                 // R10
    AST_CONST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        boot_en |-> (sel_const != '0));                                  // R9

endmodule

// File: tb/sbsel_validator_test.sv
module sbsel_validator_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bytes = '0;
    logic        boot_en, bad_sel, done;
    logic [31:0] sel_const;
    logic [7:0]  ext_id, serial_id;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    // reference state
    logic        e_done = 0, e_boot = 0, e_bad = 0;
    logic [31:0] e_const = 0;
    logic [7:0]  e_ext = 0, e_ser = 0;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sbsel_validator uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .boot_en(boot_en), .sel_const(sel_const), .ext_id(ext_id),
        .serial_id(serial_id), .bad_sel(bad_sel), .done(done)
    );

    // Behavioural decode straight from the requirement text.
    task automatic ref_decode(input logic [15:0] f, output logic ok, output logic bad,
                              output logic [31:0] c, output string tag);
        int lo, hi, zeros, base, idx;
        bit asym;
        lo = f & 8'hFF; hi = (f >> 8) & 8'hFF;
        ok = 0; bad = 1; c = 0;
        asym = 0; zeros = 0; base = 0;
        for (int k = 0; k < 4; k++) begin
            if (((lo >> k) & 1) != ((lo >> (7 - k)) & 1)) asym = 1;
            else if (((lo >> k) & 1) == 0) begin
                zeros++;
                if (zeros == 1) base = k * 16;
            end
        end
        idx = base + (hi % 16);
        if (f == 16'hFFFF) begin bad = 0; tag = "R4"; end
        else if (asym) tag = "R5";
        else if (zeros > 1) tag = "R6";
        else if (((hi % 16) ^ (hi / 16)) != 15) tag = "R7";
        else if (idx >= 2) tag = "R8";
        else begin
            ok = 1; bad = 0; tag = "R9";
            c = (idx == 0) ? 32'h0800_0100 : 32'h0C00_0180;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_done = 0; e_boot = 0; e_bad = 0; e_const = 0; e_ext = 0; e_ser = 0;
            e_tag = "R1";
        end else begin
            e_done = in_valid;
            if (in_valid) begin
                ref_decode(in_bytes[31:16], e_boot, e_bad, e_const, e_tag);
                e_ext = in_bytes[7:0];
                e_ser = in_bytes[15:8];
            end
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            if (!rst_n) begin
                // R1 reset state
                cmp("R1", {boot_en, bad_sel, done}, 3'b000, "flags in reset");
                cmp("R1", sel_const, 0, "const in reset");
                cmp("R1", {ext_id, serial_id}, 16'h0, "ids in reset");
            end else begin
                cmp("R2", done, e_done, "done");
                cmp("R3", {ext_id, serial_id}, {e_ext, e_ser}, "identity bytes");
                cmp(e_tag, boot_en, e_boot, "boot_en");
                cmp(e_tag, bad_sel, e_bad, "bad_sel");
                cmp(e_boot ? e_tag : "R10", sel_const, e_const, "sel_const");
            end
            if (cycles > WATCHDOG) begin
                misses++;
                vectors++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    task automatic apply(input logic [15:0] f, input logic [7:0] ex, input logic [7:0] sr,
                         input int gap);
        @(posedge clk); #1;
        in_valid = 1; in_bytes = {f, sr, ex};
        @(posedge clk); #1;
        in_valid = 0; in_bytes = {~f, ~sr, ~ex};
        for (int g = 0; g < gap; g++) @(posedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk);
        apply(16'hFFFF, 8'h11, 8'h22, 2);   // R4 blank
        apply(16'hF0FF, 8'h33, 8'h44, 1);   // R9 index 0
        apply(16'hE1FF, 8'h55, 8'h66, 0);   // R9 index 1
        apply(16'hF07E, 8'h77, 8'h88, 3);   // R9 index 0, zero pair at 0
        apply(16'hE17E, 8'h99, 8'hAA, 0);   // R9 index 1
        apply(16'hF0BD, 8'hBB, 8'hCC, 1);   // R8 base 16
        apply(16'hD2FF, 8'hDD, 8'hEE, 0);   // R8 index 2
        apply(16'hF0FE, 8'h01, 8'h02, 2);   // R5 asymmetric
        apply(16'hF03C, 8'h03, 8'h04, 0);   // R6 two zero pairs
        apply(16'hF1FF, 8'h05, 8'h06, 1);   // R7 nibble
        apply(16'hFFFF, 8'h07, 8'h08, 0);   // R4 after error, R10
        apply(16'hE17E, 8'h09, 8'h0A, 4);   // R2 hold over gap
        // back-to-back strobes
        @(posedge clk); #1;
        in_valid = 1; in_bytes = 32'hF0FF_1234;
        @(posedge clk); #1;
        in_bytes = 32'hF03C_5678;
        @(posedge clk); #1;
        in_bytes = 32'hE1FF_9ABC;
        @(posedge clk); #1;
        in_valid = 0;
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 5 == 0)      apply({(n % 2) ? 8'hE1 : 8'hF0, lfsr[7:0]}, lfsr[15:8], lfsr[7:0], n % 3);
            else if (n % 5 == 1) apply({lfsr[15:8], (n % 4 < 2) ? 8'hFF : 8'h7E}, lfsr[7:0], lfsr[15:8], 0);
            else                 apply(lfsr ^ 16'h5A3C, lfsr[15:8], lfsr[7:0], n % 2);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 finish_run();
    end

endmodule